// File: doc/BRIEF.md
# Serial-EEPROM configuration loader with CRC-32 check

After a synchronous reset, or when software pulses a load request, this block reads a full image from a serial EEPROM through a simple byte-read interface. The two-wire protocol engine sits behind that interface. The block copies every data byte into the configuration register space through a write port. Each data byte is also fed, most significant bit first, into an Ethernet CRC-32 engine.

The topmost four bytes of the image hold the expected CRC, most significant byte first. The byte just below them is the control word. The top bit of the control word is first written as 0. The real value of that bit is written only after the computed CRC matches the stored one.

Each load ends in one of three outcomes, and each outcome leaves a fixed pattern on the status outputs and the fault LED:

- **Success:** the data was read and the CRC matched.
- **EEPROM absent:** the first byte read was not acknowledged.
- **CRC error:** the CRC did not match, or a later byte read failed.

Top module: `cfg_loader`

## Requirements
- R1: While reset is high, and again after it is released, `stat_load` is 1 and `ee_addr` is 0. The block reads bytes at rising addresses from 0 up to 2^AW-1 (255 by default), one byte per accepted `ee_valid`.
- R2: Every byte below the control address (2^AW-5, 0xFB) is written unchanged to the same address, in rising address order. No write ever targets an address at or above 2^AW-4 (0xFC).
- R3: The CRC uses polynomial 0x04C11DB7, starts at all ones, and takes each byte MSB first over addresses 0 through 0xFB. The four bytes at 0xFC..0xFF, read MSB byte first, must equal the ones' complement of the final register.
- R4: The control byte at 0xFB is first written with bit 7 forced to 0. Only on a CRC match is it written a second time with bit 7 as stored.
- R5: On success the outputs are `stat_stop`=0, `stat_load`=0, `stat_initd`=1, `fault_led`=0 and `eclk_lock`=0.
- R6: On a CRC mismatch the outputs are `stat_stop`=1, `stat_load`=0, `stat_initd`=0, `fault_led`=1 and `eclk_lock`=0. The control byte is not rewritten.
- R7: If `ee_nack` answers the read of address 0, nothing is written and the outputs are `stat_stop`=0, `stat_load`=0, `stat_initd`=0, `fault_led`=0 and `eclk_lock`=1.
- R8: If `ee_nack` answers any later address, the load ends at once with the R6 pattern, and no further bytes are written.
- R9: A `sw_load` pulse while idle restarts the load from address 0 and clears `stat_stop`, `stat_initd`, `fault_led` and `eclk_lock`. A `sw_load` pulse while a load is running is ignored.
- R10: `eclk_out` follows `sio_clk_in` only while `stat_load`=0 and `eclk_lock`=0. Otherwise it is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; a load starts when it is released |
| sw_load | input | 1 | Software load request pulse |
| sio_clk_in | input | 1 | Software clock bit for the EEPROM clock pin |
| ee_req | output | 1 | Byte read request |
| ee_addr | output | AW | Byte address being read |
| ee_valid | input | 1 | Byte returned on `ee_data` |
| ee_nack | input | 1 | Read not acknowledged |
| ee_data | input | 8 | Returned byte |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_addr | output | AW | Configuration write address |
| cfg_wdata | output | 8 | Configuration write data |
| stat_stop | output | 1 | Device held stopped |
| stat_load | output | 1 | Load in progress |
| stat_initd | output | 1 | Configuration loaded and valid |
| fault_led | output | 1 | Fault indicator |
| eclk_lock | output | 1 | EEPROM clock locked low |
| eclk_out | output | 1 | EEPROM clock pin value from software |

## Verification
The bench runs the loader against five EEPROM images:

- **Two images with valid CRCs.** Their seeds differ, so one control byte has its top bit set and the other has it clear. This shows that the top bit is truly held back and then restored, and not simply copied.
- **An image with one stored CRC byte flipped.** This separates the match path from the mismatch path.
- **An image whose first read is refused.** This gives the absent-EEPROM pattern.
- **An image whose read fails partway through.** This shows that a late failure lands on the error pattern, not the absent one.

During one of the loads a second request is pulsed, to show that it does not restart the sequence.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int DW = 8;
    localparam int CW = 32;
    localparam logic [CW-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CW-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_READ  = 2'd1,
        LD_CHECK = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic          we;
        logic [DW-1:0] data;
    } wr_beat_t;

    // advance the CRC register by one byte, MSB first
    function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c, input logic [DW-1:0] b);
        logic [CW-1:0] r;
        logic          fb;
        r = c;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = r[CW-1] ^ b[i];
            r  = {r[CW-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_crc32.sv
module cfg_crc32
    import cfg_loader_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || init)
            crc <= CRC_SEED;
        else if (en)
            crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_loader_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_load,
    input  logic          ee_valid,
    input  logic          ee_nack,
    input  logic [DW-1:0] ee_data,
    input  logic [CW-1:0] crc,
    output logic          ee_req,
    output logic [AW-1:0] ee_addr,
    output logic          busy,
    output logic          start,
    output logic          crc_en,
    output logic          wr_we,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done_ok,
    output logic          done_bad,
    output logic          done_absent
);
    localparam logic [AW-1:0] LAST_A = '1;
    localparam logic [AW-1:0] CRC_A  = LAST_A - AW'(3);
    localparam logic [AW-1:0] CTRL_A = CRC_A - AW'(1);
    localparam logic [DW-1:0] HOLD_M = DW'(1) << (DW - 1);

    ld_state_e     state;
    logic [AW-1:0] addr;
    logic [DW-1:0] ctrl_q;
    logic [CW-1:0] crc_exp;
    wr_beat_t      beat;
    logic          match;
    logic          take;

    assign match   = (crc_exp == ~crc);
    assign take    = (state == LD_READ) && ee_valid && !ee_nack;
    assign ee_req  = (state == LD_READ);
    assign ee_addr = addr;
    assign busy    = (state != LD_IDLE);
    assign start   = sw_load && (state == LD_IDLE);
    assign crc_en  = take && (addr < CRC_A);

    assign done_absent = (state == LD_READ) && ee_nack && (addr == '0);
    assign done_bad    = ((state == LD_READ) && ee_nack && (addr != '0))
                       || ((state == LD_CHECK) && !match);
    assign done_ok     = (state == LD_CHECK) && match;

    assign wr_we   = beat.we;
    assign wr_data = beat.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LD_READ;
            addr    <= '0;
            ctrl_q  <= '0;
            crc_exp <= '0;
            beat    <= '0;
            wr_addr <= '0;
        end else begin
            beat.we <= 1'b0;
            unique case (state)
                LD_IDLE: begin
                    if (start) begin
                        state <= LD_READ;
                        addr  <= '0;
                    end
                end
                LD_READ: begin
                    if (ee_nack) begin
                        state <= LD_IDLE;
                    end else if (ee_valid) begin
                        if (addr < CRC_A) begin
                            beat.we   <= 1'b1;
                            wr_addr   <= addr;
                            beat.data <= (addr == CTRL_A) ? (ee_data & ~HOLD_M) : ee_data;
                            if (addr == CTRL_A)
                                ctrl_q <= ee_data;
                        end else begin
                            crc_exp <= {crc_exp[CW-DW-1:0], ee_data};
                        end
                        addr <= addr + AW'(1);
                        if (addr == LAST_A)
                            state <= LD_CHECK;
                    end
                end
                LD_CHECK: begin
                    state <= LD_IDLE;
                    if (match) begin
                        beat.we   <= 1'b1;
                        wr_addr   <= CTRL_A;
                        beat.data <= ctrl_q;
                    end
                end
                default: state <= LD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_status.sv
module cfg_status (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done_ok,
    input  logic done_bad,
    input  logic done_absent,
    output logic stop,
    output logic initd,
    output logic led,
    output logic lock
);
    always_ff @(posedge clk) begin
        if (rst || start) begin
            stop  <= 1'b0;
            initd <= 1'b0;
            led   <= 1'b0;
            lock  <= 1'b0;
        end else begin
            if (done_ok)
                initd <= 1'b1;
            if (done_bad) begin
                stop <= 1'b1;
                led  <= 1'b1;
            end
            if (done_absent)
                lock <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_load,
    input  logic          sio_clk_in,
    output logic          ee_req,
    output logic [AW-1:0] ee_addr,
    input  logic          ee_valid,
    input  logic          ee_nack,
    input  logic [7:0]    ee_data,
    output logic          cfg_we,
    output logic [AW-1:0] cfg_addr,
    output logic [7:0]    cfg_wdata,
    output logic          stat_stop,
    output logic          stat_load,
    output logic          stat_initd,
    output logic          fault_led,
    output logic          eclk_lock,
    output logic          eclk_out
);
    logic [CW-1:0] crc;
    logic          start, crc_en;
    logic          done_ok, done_bad, done_absent;

    cfg_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .sw_load(sw_load),
        .ee_valid(ee_valid), .ee_nack(ee_nack), .ee_data(ee_data), .crc(crc),
        .ee_req(ee_req), .ee_addr(ee_addr), .busy(stat_load), .start(start),
        .crc_en(crc_en), .wr_we(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .done_ok(done_ok), .done_bad(done_bad), .done_absent(done_absent)
    );

    cfg_crc32 u_crc (
        .clk(clk), .rst(rst), .init(start), .en(crc_en), .din(ee_data), .crc(crc)
    );

    cfg_status u_stat (
        .clk(clk), .rst(rst), .start(start),
        .done_ok(done_ok), .done_bad(done_bad), .done_absent(done_absent),
        .stop(stat_stop), .initd(stat_initd), .led(fault_led), .lock(eclk_lock)
    );

    assign eclk_out = sio_clk_in && !stat_load && !eclk_lock;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_addr,
    input logic [7:0]    cfg_wdata,
    input logic          stat_stop,
    input logic          stat_load,
    input logic          stat_initd,
    input logic          fault_led,
    input logic          eclk_lock,
    input logic          eclk_out
);
    localparam logic [AW-1:0] CRC_A  = {AW{1'b1}} - AW'(3);
    localparam logic [AW-1:0] CTRL_A = CRC_A - AW'(1);

    // R2
    wr_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> (cfg_addr < CRC_A));

    // R4
    hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && stat_load && cfg_addr == CTRL_A) |-> !cfg_wdata[7]);

    // R5
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat_initd && stat_stop));

    // R6
    led_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
        fault_led |-> stat_stop);

    // R7
    lock_alone_chk: assert property (@(posedge clk) disable iff (rst)
        eclk_lock |-> (!stat_initd && !stat_stop && !fault_led));

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_load) |-> (!fault_led && !stat_initd && !eclk_lock && !stat_stop));

    // R10
    clk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_load || eclk_lock) |-> !eclk_out);
endmodule

bind cfg_loader cfg_loader_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .stat_stop(stat_stop), .stat_load(stat_load), .stat_initd(stat_initd),
    .fault_led(fault_led), .eclk_lock(eclk_lock), .eclk_out(eclk_out)
);

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
    localparam int AW   = 8;
    localparam int CTRL = 251;
    localparam int CRCA = 252;
    localparam int M_GOOD = 0, M_BAD = 1, M_ABSENT = 2, M_MIDNACK = 3;
    localparam int NACK_AT = 100;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  seed;
        logic        x_stop;
        logic        x_initd;
        logic        x_led;
        logic        x_lock;
        logic [15:0] nwr;
        logic        retrig;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{2'd0, 8'h85, 1'b0, 1'b1, 1'b0, 1'b0, 16'd253, 1'b0},
        '{2'd1, 8'h13, 1'b1, 1'b0, 1'b1, 1'b0, 16'd252, 1'b0},
        '{2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0,   1'b0},
        '{2'd3, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 16'd100, 1'b0},
        '{2'd0, 8'h13, 1'b0, 1'b1, 1'b0, 1'b0, 16'd253, 1'b1}
    };

    logic clk = 0, rst = 1, sw_load = 0, sio_clk_in = 0;
    logic ee_req, ee_valid = 0, ee_nack = 0;
    logic [AW-1:0] ee_addr, cfg_addr;
    logic [7:0] ee_data = 0, cfg_wdata;
    logic cfg_we, stat_stop, stat_load, stat_initd, fault_led, eclk_lock, eclk_out;

    int checks = 0, errors = 0;
    int mode = M_GOOD;
    logic [7:0] seed = 8'h85;
    logic [31:0] img_crc;
    int nwr, ord_err, dat_err, next_a, ctrl_cnt;
    logic [7:0] ctrl_first, ctrl_last;

    always #5 clk = ~clk;

    cfg_loader #(.AW(AW)) uut (.*);

    function automatic logic [31:0] ref_crc(input logic [7:0] s);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int a = 0; a <= CTRL; a++) begin
            logic [7:0] b = (a == CTRL) ? s : 8'((a * 3) + s);
            c = c ^ {b, 24'h0};
            for (int k = 0; k < 8; k++)
                c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] rom(input int a);
        if (a < CTRL) return 8'((a * 3) + seed);
        if (a == CTRL) return seed;
        case (a)
            252: return img_crc[31:24];
            253: return img_crc[23:16];
            254: return img_crc[15:8] ^ ((mode == M_BAD) ? 8'h01 : 8'h00);
            default: return img_crc[7:0];
        endcase
    endfunction

    // EEPROM byte model
    always @(negedge clk) begin
        if (ee_req && !ee_valid && !ee_nack) begin
            if (mode == M_ABSENT || (mode == M_MIDNACK && int'(ee_addr) == NACK_AT))
                ee_nack = 1;
            else begin
                ee_valid = 1;
                ee_data  = rom(int'(ee_addr));
            end
        end else begin
            ee_valid = 0;
            ee_nack  = 0;
        end
    end

    // write monitor
    always @(negedge clk) begin
        if (cfg_we) begin
            nwr++;
            if (int'(cfg_addr) == CTRL && ctrl_cnt > 0) begin
                ctrl_last = cfg_wdata;
                ctrl_cnt++;
            end else begin
                if (int'(cfg_addr) != next_a) ord_err++;
                if (int'(cfg_addr) == CTRL) begin
                    ctrl_first = cfg_wdata;
                    ctrl_cnt++;
                end else if (cfg_wdata != rom(int'(cfg_addr))) dat_err++;
                next_a++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        nwr = 0; ord_err = 0; dat_err = 0; next_a = 0; ctrl_cnt = 0;
        ctrl_first = 0; ctrl_last = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (stat_load && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        sio_clk_in = 1;
        for (int v = 0; v < 5; v++) begin
            mode    = int'(VEC[v].mode);
            seed    = VEC[v].seed;
            img_crc = ref_crc(seed);
            clr_mon();
            if (v == 0) begin
                repeat (3) @(negedge clk);
                chk("R1 load in reset", int'(stat_load), 1);
                rst = 0;
                @(negedge clk);
                chk("R1 reset initd", int'(stat_initd), 0);
                chk("R1 reset led", int'(fault_led), 0);
                chk("R10 clk held in load", int'(eclk_out), 0);
            end else begin
                @(negedge clk); sw_load = 1;
                @(negedge clk); sw_load = 0;
                chk("R9 restart load", int'(stat_load), 1);
                chk("R9 led cleared", int'(fault_led), 0);
                chk("R9 lock cleared", int'(eclk_lock), 0);
                if (VEC[v].retrig) begin
                    repeat (40) @(negedge clk);
                    sw_load = 1; @(negedge clk); sw_load = 0;
                end
            end
            wait_idle();
            chk("R5 R6 R7 stop", int'(stat_stop), int'(VEC[v].x_stop));
            chk("R5 R6 R7 load done", int'(stat_load), 0);
            chk("R5 R6 R7 initd", int'(stat_initd), int'(VEC[v].x_initd));
            chk("R6 fault led", int'(fault_led), int'(VEC[v].x_led));
            chk("R7 clock lock", int'(eclk_lock), int'(VEC[v].x_lock));
            chk("R8 R9 write count", nwr, int'(VEC[v].nwr));
            chk("R1 R2 write order", ord_err, 0);
            chk("R2 write data", dat_err, 0);
            chk("R10 clk follow", int'(eclk_out), (VEC[v].x_lock) ? 0 : 1);
            if (mode == M_GOOD) begin
                chk("R4 first ctrl masked", int'(ctrl_first), int'(seed & 8'h7F));
                chk("R3 R4 ctrl restored", int'(ctrl_last), int'(seed));
                chk("R4 ctrl writes", ctrl_cnt, 2);
            end else if (mode == M_BAD) begin
                chk("R6 no restore", ctrl_cnt, 1);
                chk("R6 masked only", int'(ctrl_first), int'(seed & 8'h7F));
            end
        end
        // R10: software clock passes through when idle and unlocked
        sio_clk_in = 0; @(negedge clk);
        chk("R10 clk low follow", int'(eclk_out), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule